// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge and Completion Interface

This block sits between a set of interrupt sources and one processor. Each cycle it receives a pending bit, an enable bit and an 8-bit priority for every interrupt ID. From these it picks the most urgent candidate that the processor may take now. The processor reads this candidate with a destructive acknowledge, which marks the interrupt active and pushes its priority as the new running priority. It can also read the same value with a peek, which changes nothing. Lower priority values are more urgent. A candidate must be more urgent than both a programmable priority mask and the current running priority.

Completion happens in one step or in two. With split completion off, an end-of-interrupt write pops the running priority and also clears the active state. With split completion on, the end-of-interrupt write only pops the running priority. A later deactivate write with the same ID clears the active state. IDs are 16 bits wide, and values 1020 and above are reserved. IDs 0–15 are software-generated, 16–31 are private to the processor, and 32 and up are shared. All IDs are handled alike here. Pending is owned by the source. A level source that is still asserted while its ID is active is active-and-pending, and it is taken again once it is deactivated.

Top module: `intr_cpu_if`

## Requirements
- R1: After reset the read data is 1023, the running priority is 0xFF, the request output is low, the priority mask is 0x00 (nothing passes) and no interrupt is active.
- R2: An ID is a candidate when it is enabled, pending and not active, and its priority value is strictly below both the mask and the running priority. The lowest priority value wins, and on a tie the lowest ID wins. The request output is high whenever a candidate exists.
- R3: An acknowledge read places the winning ID on the read data one cycle later, with the read-valid output high. From that cycle on, the ID is active and its priority is the running priority.
- R4: An acknowledge read with no candidate returns 1023 and changes no state.
- R5: A peek read returns the same ID that an acknowledge in that cycle would return (1023 if none). It leaves the active state and the running priority unchanged.
- R6: A mask write takes effect from the next cycle. A mask of 0xFF passes priorities 0x00–0xFE, and a mask of m blocks every priority of m or more.
- R7: While an interrupt is running, only a strictly more urgent candidate can be acknowledged. It nests, and each completion restores the priority beneath it.
- R8: With split completion off, an end-of-interrupt write whose ID is on top of the running-priority stack pops the stack and clears that ID's active state.
- R9: With split completion on, an end-of-interrupt write only pops the stack. The ID stays active, and cannot be acknowledged, until a deactivate write with that ID.
- R10: An end-of-interrupt write whose ID is not on top of the stack is ignored.
- R11: A deactivate write is ignored while split completion is off.
- R12: A level source that stays pending through completion is offered and acknowledged again once its active state clears.
- R13: The stack holds STACK_DEPTH entries. While it is full, nothing is a candidate and an acknowledge returns 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pend | input | N_IRQ | Pending bit per ID |
| src_en | input | N_IRQ | Enable bit per ID |
| src_prio | input | 8*N_IRQ | Priority per ID, ID i in bits [8i+7:8i] |
| split_eoi | input | 1 | 1: end-of-interrupt only drops priority; 0: it also deactivates |
| ack_rd | input | 1 | Destructive acknowledge read strobe |
| peek_rd | input | 1 | Non-destructive highest-pending read strobe |
| mask_wr | input | 1 | Priority-mask write strobe |
| mask_val | input | 8 | Priority-mask write value |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_id | input | 16 | End-of-interrupt ID |
| dir_wr | input | 1 | Deactivate write strobe |
| dir_id | input | 16 | Deactivate ID |
| rd_data | output | 16 | ID returned by the last acknowledge or peek |
| rd_valid | output | 1 | High the cycle after a read strobe |
| irq_req | output | 1 | A candidate exists |
| run_prio | output | 8 | Current running priority (0xFF when idle) |

## Verification
Read results are registered, so rd_data and rd_valid are due one clock after the cycle that holds the read strobe. The bench raises a strobe at a falling edge, drops it at the next falling edge, and compares the read data there. Mask, completion and deactivate writes, and acknowledge side effects, change run_prio and the candidate set at the same rising edge. irq_req and a follow-up peek therefore reflect them one cycle after the strobe, and are checked at the following falling edge. Source-vector changes reach irq_req within the same cycle, so those are checked a fraction of a period after driving.

// File: rtl/intr_cpu_if.sv
module intr_cpu_if #(
  parameter int N_IRQ       = 32,
  parameter int STACK_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_IRQ-1:0]   src_pend,
  input  logic [N_IRQ-1:0]   src_en,
  input  logic [8*N_IRQ-1:0] src_prio,
  input  logic               split_eoi,
  input  logic               ack_rd,
  input  logic               peek_rd,
  input  logic               mask_wr,
  input  logic [7:0]         mask_val,
  input  logic               eoi_wr,
  input  logic [15:0]        eoi_id,
  input  logic               dir_wr,
  input  logic [15:0]        dir_id,
  output logic [15:0]        rd_data,
  output logic               rd_valid,
  output logic               irq_req,
  output logic [7:0]         run_prio
);
  localparam int SPW = $clog2(STACK_DEPTH + 1);
  localparam int TIW = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam int IW  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
  localparam logic [15:0] NO_IRQ = 16'd1023;

  logic [N_IRQ-1:0] active;
  logic [7:0]       mask;
  logic [SPW-1:0]   sp;
  logic [7:0]       stk_pr [STACK_DEPTH];
  logic [15:0]      stk_id [STACK_DEPTH];

  logic [TIW-1:0] top;
  logic           full;
  logic           best_ok;
  logic [15:0]    best_id;
  logic [7:0]     best_pr;
  logic           eoi_hit;

  assign top      = TIW'(sp - 1'b1);
  assign full     = (sp == SPW'(STACK_DEPTH));
  assign run_prio = (sp == '0) ? 8'hFF : stk_pr[top];
  assign eoi_hit  = eoi_wr && (sp != '0) && (eoi_id == stk_id[top]);
  assign irq_req  = best_ok;

  always_comb begin
    best_ok = 1'b0;
    best_id = NO_IRQ;
    best_pr = 8'hFF;
    for (int i = 0; i < N_IRQ; i++) begin
      logic [7:0] p;
      p = src_prio[8*i +: 8];
      if (src_pend[i] && src_en[i] && !active[i] && !full &&
          p < mask && p < run_prio && (!best_ok || p < best_pr)) begin
        best_ok = 1'b1;
        best_id = 16'(i);
        best_pr = p;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= '0;
      mask     <= 8'h00;
      sp       <= '0;
      rd_data  <= NO_IRQ;
      rd_valid <= 1'b0;
      for (int k = 0; k < STACK_DEPTH; k++) begin
        stk_pr[k] <= 8'hFF;
        stk_id[k] <= NO_IRQ;
      end
    end else begin
      rd_valid <= ack_rd || peek_rd;
      if (ack_rd || peek_rd) rd_data <= best_id;
      if (mask_wr) mask <= mask_val;
      if (ack_rd && best_ok) begin
        active[best_id[IW-1:0]] <= 1'b1;
        stk_pr[TIW'(sp)]        <= best_pr;
        stk_id[TIW'(sp)]        <= best_id;
        sp                      <= sp + 1'b1;
      end else if (eoi_hit) begin
        sp <= sp - 1'b1;
        if (!split_eoi && eoi_id < 16'(N_IRQ)) active[eoi_id[IW-1:0]] <= 1'b0;
      end
      if (dir_wr && split_eoi && dir_id < 16'(N_IRQ))
        active[dir_id[IW-1:0]] <= 1'b0;
    end
  end
endmodule

// File: rtl/intr_cpu_if_chk.sv
module intr_cpu_if_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ack_rd,
  input logic        peek_rd,
  input logic        eoi_wr,
  input logic [15:0] rd_data,
  input logic        rd_valid,
  input logic        irq_req,
  input logic [7:0]  run_prio
);
  a_r3_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd || peek_rd) |=> rd_valid);
  a_r4_empty_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !irq_req) |=> (rd_data == 16'd1023));
  a_r3_ack_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && irq_req) |=> (run_prio < $past(run_prio)));
  a_r5_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_rd && !eoi_wr) |=> $stable(run_prio));
  a_r10_eoi_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_rd && eoi_wr) |=> (run_prio >= $past(run_prio)));
  a_r3_ack_real_id: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && irq_req) |=> (rd_data < 16'd1020));
endmodule

bind intr_cpu_if intr_cpu_if_chk u_chk (.*);

// File: tb/sim_intr_cpu_if.sv
module sim_intr_cpu_if;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_pend = '0, src_en = '0;
  logic [8*N-1:0] src_prio = '1;
  logic split_eoi = 1'b0, ack_rd = 1'b0, peek_rd = 1'b0, mask_wr = 1'b0;
  logic [7:0] mask_val = '0;
  logic eoi_wr = 1'b0, dir_wr = 1'b0;
  logic [15:0] eoi_id = '0, dir_id = '0;
  logic [15:0] rd_data;
  logic rd_valid, irq_req;
  logic [7:0] run_prio;
  int n_chk = 0, n_bad = 0;

  intr_cpu_if #(.N_IRQ(N), .STACK_DEPTH(4)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic src(input int id, input logic p, input logic e, input logic [7:0] pr);
    src_pend[id] = p; src_en[id] = e; src_prio[8*id +: 8] = pr;
  endtask

  task automatic clear_src();
    src_pend = '0; src_en = '0; src_prio = '1;
  endtask

  task automatic rd(input bit ack, input string req, input int exp);
    @(negedge clk); ack_rd = ack; peek_rd = !ack;
    @(negedge clk); ack_rd = 0; peek_rd = 0;
    chk(req, rd_data, exp);
    chk({req, " valid"}, rd_valid, 1);
  endtask

  task automatic set_mask(input logic [7:0] m);
    @(negedge clk); mask_wr = 1; mask_val = m;
    @(negedge clk); mask_wr = 0;
  endtask

  task automatic eoi(input int id);
    @(negedge clk); eoi_wr = 1; eoi_id = 16'(id);
    @(negedge clk); eoi_wr = 0;
  endtask

  task automatic dir(input int id);
    @(negedge clk); dir_wr = 1; dir_id = 16'(id);
    @(negedge clk); dir_wr = 0;
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 1023);
    chk("R1 run_prio", run_prio, 8'hFF);
    src(5, 1, 1, 8'h10); #1;
    chk("R1 mask 0 blocks", irq_req, 0);
    rd(1, "R4 ack none", 1023);
    chk("R4 run_prio unchanged", run_prio, 8'hFF);
    clear_src();
  endtask

  task automatic t_select();
    set_mask(8'hFF);
    src(3, 1, 1, 8'h40); src(7, 1, 1, 8'h20); src(9, 1, 1, 8'h20); src(2, 1, 0, 8'h00);
    #1 chk("R2 irq_req", irq_req, 1);
    rd(0, "R5 peek tie lowest ID", 7);
    rd(0, "R5 peek repeat", 7);
    chk("R5 peek keeps run_prio", run_prio, 8'hFF);
    rd(1, "R3 ack", 7);
    chk("R3 run_prio", run_prio, 8'h20);
    rd(1, "R7 equal prio not taken", 1023);
    eoi(7);
    chk("R8 eoi pops", run_prio, 8'hFF);
    rd(1, "R12 level retaken", 7);
    eoi(7);
    src(7, 0, 1, 8'h20);
    rd(1, "R2 next winner", 9);
    eoi(9);
    clear_src();
  endtask

  task automatic t_mask();
    set_mask(8'h30);
    src(3, 1, 1, 8'h40); #1;
    chk("R6 mask blocks", irq_req, 0);
    src(4, 1, 1, 8'h2F);
    rd(0, "R6 below mask passes", 4);
    src(4, 0, 0, 8'hFF); src(3, 1, 1, 8'h30);
    rd(0, "R6 equal to mask blocked", 1023);
    set_mask(8'hFF);
    src(3, 0, 0, 8'hFF); src(6, 1, 1, 8'hFE);
    rd(0, "R6 0xFF passes 0xFE", 6);
    clear_src();
  endtask

  task automatic t_nest();
    split_eoi = 0;
    src(10, 1, 1, 8'h80);
    rd(1, "R7 first", 10);
    src(11, 1, 1, 8'h40);
    rd(1, "R7 nested", 11);
    chk("R7 run_prio nested", run_prio, 8'h40);
    eoi(10);
    chk("R10 non-top eoi ignored", run_prio, 8'h40);
    eoi(11);
    chk("R7 restore", run_prio, 8'h80);
    eoi(10);
    chk("R8 idle", run_prio, 8'hFF);
    clear_src();
  endtask

  task automatic t_split();
    split_eoi = 1;
    src(12, 1, 1, 8'h50);
    rd(1, "R9 ack", 12);
    eoi(12);
    chk("R9 eoi drops prio", run_prio, 8'hFF);
    rd(0, "R9 still active", 1023);
    dir(12);
    rd(0, "R9 deactivated", 12);
    rd(1, "R11 ack", 12);
    eoi(12);
    split_eoi = 0;
    dir(12);
    rd(0, "R11 dir ignored", 1023);
    split_eoi = 1;
    dir(12);
    rd(0, "R11 dir after split", 12);
    split_eoi = 0;
    clear_src();
  endtask

  task automatic t_depth();
    for (int k = 0; k < 4; k++) begin
      src(20 + k, 1, 1, 8'(8'h90 - 8'h10 * k));
      rd(1, "R13 fill", 20 + k);
    end
    chk("R13 run_prio", run_prio, 8'h60);
    src(24, 1, 1, 8'h50); #1;
    chk("R13 full no req", irq_req, 0);
    rd(1, "R13 full ack", 1023);
    for (int k = 3; k >= 0; k--) eoi(20 + k);
    chk("R13 unwound", run_prio, 8'hFF);
    rd(1, "R13 space again", 24);
    eoi(24);
    clear_src();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset(); t_select(); t_mask(); t_nest(); t_split(); t_depth();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule